// File: doc/BRIEF.md
# Memory Test Pattern Sequencer

This block is a self-running memory exerciser placed on the user side of a memory controller. It has no host access. After reset it fills a fixed address window with a 16-bit walking pattern. The upper byte walks a single one and the lower byte walks a single zero, and both bytes rotate by one bit on every word. Once the whole window is written, the block reads the window back in the same order. It compares every returned word with a pattern it regenerates locally. When the pass is over it scores the pass as a whole.

Commands go to the controller over a plain request/acknowledge interface. The block raises a request with the command kind, address and write data, and holds all of them until the controller acknowledges. Read data comes back in issue order, marked by a valid strobe. Any number of reads may be in flight, so the controller's read latency has no effect on the result.

Between passes the seed changes, so that no location holds the same value in two consecutive passes. Two small counters, one for clean passes and one for failed passes, are the only results. They are sized to drive a bank of four indicators each.

Top module: `mem_test_seq`

## Requirements
- R1: When `rst` (active high, synchronous) is high, both counters go to 0 and `cmd_valid` goes to 0. The first command after reset is a write of 0x01FE to address 0.
- R2: Each data word has an upper byte (bits 15..8) and a lower byte (bits 7..0). From one write to the next in a pass, each byte rotates left by one bit within itself, so the pattern repeats every 8 words. Each byte therefore always has exactly one bit set, or exactly one bit clear.
- R3: Write addresses start at 0 and rise by the stride (4) up to the last address of the window, inclusive. No command address ever lies beyond the last address.
- R4: All writes of a pass are accepted before any read of that pass. Reads then start again at address 0 and use the same stride up to the last address. No write is issued during the read phase.
- R5: While `cmd_valid` is high and `cmd_ack` is low, `cmd_valid`, `cmd_write`, `cmd_addr` and `cmd_wdata` hold their values into the next cycle. A command counts as accepted in a cycle where both `cmd_valid` and `cmd_ack` are high.
- R6: The seed of the next pass is formed by rotating each byte of the current seed left by one bit and then inverting all bits. The first four pass seeds are therefore 0x01FE, 0xFD02, 0x04FB and 0xF708.
- R7: A pass in which one or more returned words differ from their expected values raises `fail_count` by exactly one, however many words were wrong, and leaves `pass_count` unchanged.
- R8: A pass in which every returned word matches raises `pass_count` by exactly one and leaves `fail_count` unchanged.
- R9: Both counters are 4 bits wide and wrap from 15 to 0.
- R10: Returned data is checked in arrival order, one word for each `rd_valid` strobe. A pass is scored only after every read issued in that pass has returned, whatever the read latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | output | 1 | Command request |
| cmd_write | output | 1 | 1 = write, 0 = read |
| cmd_addr | output | ADDR_W | Command address |
| cmd_wdata | output | DATA_W | Write data |
| cmd_ack | input | 1 | Controller accepts the pending command |
| rd_valid | input | 1 | Returned read word is valid |
| rd_data | input | DATA_W | Returned read word |
| pass_count | output | CNT_W | Number of clean passes, modulo 16 |
| fail_count | output | CNT_W | Number of failed passes, modulo 16 |

## Verification
The assertions check several rules on every cycle: a pending command is held stable until it is acknowledged, and addresses stay inside the window. Each byte of both pattern generators stays a walking one or a walking zero. Counters only ever step by one, and only one counter moves at a time. Scoring happens only with no read in flight, and the error flag stays set once set. Other properties only the bench scenarios can show. Among them are the exact address and data sequence of each pass, the seed progression across passes, and the write-then-read ordering. So are the counts after passes that have one or several corrupted words, wrap of both counters, and a reset in the middle of a pass. The bench's memory stalls acknowledges and returns reads with a deep fixed latency, so the design runs with many reads outstanding.

// File: rtl/mts_pkg.sv
package mts_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WRITE,
    ST_WACK,
    ST_RISSUE,
    ST_RDRAIN,
    ST_SCORE
  } seq_state_t;

endpackage

// File: rtl/mts_lane_rotate.sv
module mts_lane_rotate #(
  parameter int DATA_W = 16,
  parameter int LANE_W = 8
) (
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  localparam int LANES = DATA_W / LANE_W;

  // Each lane rotates left by one bit, independently of its neighbours.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign dout[g*LANE_W +: LANE_W] =
      {din[g*LANE_W +: LANE_W-1], din[g*LANE_W + LANE_W - 1]};
  end
endmodule

// File: rtl/mts_pattern_gen.sv
module mts_pattern_gen #(
  parameter int                DATA_W    = 16,
  parameter int                LANE_W    = 8,
  parameter logic [DATA_W-1:0] INIT_SEED = 16'h01FE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] seed,
  input  logic              step,
  output logic [DATA_W-1:0] word
);
  localparam int LANES = DATA_W / LANE_W;

  logic [DATA_W-1:0] word_rot;

  mts_lane_rotate #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_rot (
    .din (word),
    .dout(word_rot)
  );

  always_ff @(posedge clk) begin
    if (rst)       word <= INIT_SEED;
    else if (load) word <= seed;
    else if (step) word <= word_rot;
  end

  // R2: every lane stays a walking one or a walking zero
  for (genvar g = 0; g < LANES; g++) begin : g_shape
    a_r2_lane_shape: assert property (@(posedge clk) disable iff (rst)
      ($countones(word[g*LANE_W +: LANE_W]) == 1) ||
      ($countones(word[g*LANE_W +: LANE_W]) == LANE_W - 1));
  end
endmodule

// File: rtl/mts_read_check.sv
module mts_read_check #(
  parameter int                DATA_W    = 16,
  parameter int                LANE_W    = 8,
  parameter logic [DATA_W-1:0] INIT_SEED = 16'h01FE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] seed,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data,
  output logic              err
);
  logic [DATA_W-1:0] expect_word;

  // Expected data walks one step per returned word, in arrival order.
  mts_pattern_gen #(.DATA_W(DATA_W), .LANE_W(LANE_W), .INIT_SEED(INIT_SEED)) u_exp (
    .clk (clk),
    .rst (rst),
    .load(start),
    .seed(seed),
    .step(rd_valid),
    .word(expect_word)
  );

  always_ff @(posedge clk) begin
    if (rst || start)                           err <= 1'b0;
    else if (rd_valid && rd_data != expect_word) err <= 1'b1;
  end

  // R7: once a mismatch is seen it stays recorded until the next pass
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (rst)
    err && !start |=> err);
endmodule

// File: rtl/mts_score.sv
module mts_score #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bump,
  input  logic             failed,
  output logic [CNT_W-1:0] pass_count,
  output logic [CNT_W-1:0] fail_count
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pass_count <= '0;
      fail_count <= '0;
    end else if (bump) begin
      if (failed) fail_count <= fail_count + 1'b1;
      else        pass_count <= pass_count + 1'b1;
    end
  end

  // R7, R9: fail counter only steps by one (with wrap) and never with the pass counter
  a_r7_fail_single_step: assert property (@(posedge clk) disable iff (rst)
    (fail_count != $past(fail_count)) |->
      (fail_count == CNT_W'($past(fail_count) + 1'b1)) && $stable(pass_count));

  // R8, R9: same for the pass counter
  a_r8_pass_single_step: assert property (@(posedge clk) disable iff (rst)
    (pass_count != $past(pass_count)) |->
      (pass_count == CNT_W'($past(pass_count) + 1'b1)) && $stable(fail_count));
endmodule

// File: rtl/mem_test_seq.sv
module mem_test_seq
  import mts_pkg::*;
#(
  parameter int                ADDR_W    = 24,
  parameter int                DATA_W    = 16,
  parameter int                LANE_W    = 8,
  parameter int                STRIDE    = 4,
  parameter logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(24'h07FFFC),
  parameter logic [DATA_W-1:0] INIT_SEED = 16'h01FE,
  parameter int                CNT_W     = 4,
  parameter int                OUTST_W   = 6
) (
  input  logic              clk,
  input  logic              rst,
  output logic              cmd_valid,
  output logic              cmd_write,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_wdata,
  input  logic              cmd_ack,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data,
  output logic [CNT_W-1:0]  pass_count,
  output logic [CNT_W-1:0]  fail_count
);
  localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(STRIDE);

  seq_state_t        state;
  logic [DATA_W-1:0] seed;
  logic [DATA_W-1:0] seed_rot;
  logic [DATA_W-1:0] wr_word;
  logic [OUTST_W-1:0] outstanding;
  logic              pass_err;
  logic              accept;
  logic              rd_accept;
  logic              at_last;

  assign accept    = cmd_valid && cmd_ack;
  assign rd_accept = accept && !cmd_write;
  assign at_last   = (cmd_addr == LAST_ADDR);

  // Seed for the next pass: rotate each lane, then invert.
  mts_lane_rotate #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_seed_rot (
    .din (seed),
    .dout(seed_rot)
  );

  always_ff @(posedge clk) begin
    if (rst)                    seed <= INIT_SEED;
    else if (state == ST_SCORE) seed <= ~seed_rot;
  end

  // Write-side pattern: reloaded at pass start, advanced on each accepted write.
  mts_pattern_gen #(.DATA_W(DATA_W), .LANE_W(LANE_W), .INIT_SEED(INIT_SEED)) u_wr_pat (
    .clk (clk),
    .rst (rst),
    .load(state == ST_IDLE),
    .seed(seed),
    .step(state == ST_WACK && cmd_ack),
    .word(wr_word)
  );

  mts_read_check #(.DATA_W(DATA_W), .LANE_W(LANE_W), .INIT_SEED(INIT_SEED)) u_check (
    .clk     (clk),
    .rst     (rst),
    .start   (state == ST_IDLE),
    .seed    (seed),
    .rd_valid(rd_valid),
    .rd_data (rd_data),
    .err     (pass_err)
  );

  mts_score #(.CNT_W(CNT_W)) u_score (
    .clk       (clk),
    .rst       (rst),
    .bump      (state == ST_SCORE),
    .failed    (pass_err),
    .pass_count(pass_count),
    .fail_count(fail_count)
  );

  // Reads in flight: issued but not yet returned.
  always_ff @(posedge clk) begin
    if (rst) outstanding <= '0;
    else begin
      case ({rd_accept, rd_valid})
        2'b10:   outstanding <= outstanding + 1'b1;
        2'b01:   outstanding <= outstanding - 1'b1;
        default: outstanding <= outstanding;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cmd_valid <= 1'b0;
      cmd_write <= 1'b0;
      cmd_addr  <= '0;
      cmd_wdata <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          cmd_addr <= '0;
          state    <= ST_WRITE;
        end
        ST_WRITE: begin
          cmd_valid <= 1'b1;
          cmd_write <= 1'b1;
          cmd_wdata <= wr_word;
          state     <= ST_WACK;
        end
        ST_WACK: begin
          if (cmd_ack) begin
            if (at_last) begin
              cmd_valid <= 1'b1;
              cmd_write <= 1'b0;
              cmd_addr  <= '0;
              state     <= ST_RISSUE;
            end else begin
              cmd_valid <= 1'b0;
              cmd_addr  <= cmd_addr + ADDR_STEP;
              state     <= ST_WRITE;
            end
          end
        end
        ST_RISSUE: begin
          if (cmd_ack) begin
            if (at_last) begin
              cmd_valid <= 1'b0;
              state     <= ST_RDRAIN;
            end else begin
              cmd_addr <= cmd_addr + ADDR_STEP;
            end
          end
        end
        ST_RDRAIN: begin
          if (outstanding == '0) state <= ST_SCORE;
        end
        ST_SCORE: begin
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R5: a pending command holds until acknowledged
  a_r5_cmd_hold: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && !cmd_ack |=>
      cmd_valid && $stable(cmd_write) && $stable(cmd_addr) && $stable(cmd_wdata));

  // R3: no address outside the window
  a_r3_addr_in_window: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> cmd_addr <= LAST_ADDR);

  // R10: scoring only with every read returned
  a_r10_drained_at_score: assert property (@(posedge clk) disable iff (rst)
    state == ST_SCORE |-> outstanding == '0 && !rd_valid);

  // R10: in-flight counter never wraps
  a_r10_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (outstanding == '1) |-> !(rd_accept && !rd_valid));
endmodule

// File: tb/mem_test_seq_test.sv
module mem_test_seq_test;
  localparam int AW    = 8;
  localparam int NW    = 16;
  localparam int LAT   = 6;
  localparam int NPASS = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic          cmd_valid, cmd_write, cmd_ack;
  logic [AW-1:0] cmd_addr;
  logic [15:0]   cmd_wdata, rd_data;
  logic          rd_valid;
  logic [3:0]    pass_count, fail_count;

  mem_test_seq #(
    .ADDR_W   (AW),
    .LAST_ADDR(8'h3C)
  ) uut (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_write (cmd_write),
    .cmd_addr  (cmd_addr),
    .cmd_wdata (cmd_wdata),
    .cmd_ack   (cmd_ack),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .pass_count(pass_count),
    .fail_count(fail_count)
  );

  int nchk = 0, nerr = 0;
  int pass_no = 0, widx = 0, ridx = 0;
  int cyc = 0;
  bit timed_out = 0;

  function automatic logic [7:0] rotn(logic [7:0] b, int n);
    int k = n % 8;
    if (k == 0) return b;
    return (b << k) | (b >> (8 - k));
  endfunction

  function automatic logic [15:0] seed_of(int p);
    logic [15:0] s = 16'h01FE;
    for (int i = 0; i < p; i++) s = ~{rotn(s[15:8], 1), rotn(s[7:0], 1)};
    return s;
  endfunction

  function automatic logic [15:0] exp_word(int p, int k);
    logic [15:0] s = seed_of(p);
    return {rotn(s[15:8], k), rotn(s[7:0], k)};
  endfunction

  // Odd passes get corrupted words: 1 word when p%4==1, 3 words when p%4==3.
  function automatic bit corrupt_hit(int p, int i);
    if (p % 2 == 0) return 1'b0;
    return i < ((p % 4 == 1) ? 1 : 3);
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Behavioural memory: stalling acknowledge, in-order reads with fixed latency.
  logic [15:0]    mem [NW];
  logic [LAT-1:0] pv;
  logic [15:0]    pd [LAT];
  logic [7:0]     lfsr;

  always @(posedge clk) begin
    if (rst) begin
      cmd_ack <= 1'b0;
      pv      <= '0;
      lfsr    <= 8'hA5;
    end else begin
      lfsr    <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      cmd_ack <= cmd_valid && !cmd_ack && (lfsr[0] | lfsr[2]);
      pv      <= {pv[LAT-2:0], cmd_valid && cmd_ack && !cmd_write};
      for (int i = LAT - 1; i > 0; i--) pd[i] <= pd[i-1];
      pd[0] <= mem[cmd_addr[5:2]] ^
               (corrupt_hit(pass_no, int'(cmd_addr[5:2])) ? 16'h0010 : 16'h0000);
      if (cmd_valid && cmd_ack && cmd_write) mem[cmd_addr[5:2]] <= cmd_wdata;
    end
  end

  assign rd_valid = pv[LAT-1];
  assign rd_data  = pd[LAT-1];

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) timed_out = 1'b1;
  end

  // Monitor, sampled at the falling edge: a command seen here with ack high
  // is the one accepted at the next rising edge.
  logic [15:0] seeds_lit [4] = '{16'h01FE, 16'hFD02, 16'h04FB, 16'hF708};
  bit          hold_p;
  logic [AW-1:0] h_addr;
  logic [15:0]   h_data;
  logic          h_wr;
  logic [3:0]    pc_p, fc_p;

  always @(negedge clk) begin
    if (rst) begin
      widx = 0; ridx = 0; pass_no = 0; hold_p = 0; pc_p = 0; fc_p = 0;
    end else begin
      if (hold_p)
        check(cmd_valid && cmd_addr == h_addr && cmd_wdata == h_data && cmd_write == h_wr,
              "R5 command held until ack", {cmd_valid, cmd_addr}, {1'b1, h_addr});
      if (pass_count != pc_p || fail_count != fc_p)
        check(pv == '0, "R10 scored with reads in flight", int'(pv), 0);
      if (cmd_valid && cmd_ack) begin
        if (cmd_write) begin
          if (widx == NW && ridx == NW) begin
            pass_no++;
            widx = 0; ridx = 0;
            check(pass_count == 4'((pass_no + 1) / 2), "R8 R9 pass count",
                  pass_count, (pass_no + 1) / 2 % 16);
            check(fail_count == 4'(pass_no / 2), "R7 R9 fail count",
                  fail_count, pass_no / 2 % 16);
          end
          if (widx < NW) begin
            check(cmd_addr == AW'(widx * 4), "R3 write address", cmd_addr, widx * 4);
            check(cmd_wdata == exp_word(pass_no, widx), "R2 write data",
                  cmd_wdata, exp_word(pass_no, widx));
            if (widx == 0 && pass_no < 4)
              check(cmd_wdata == seeds_lit[pass_no], "R6 pass seed",
                    cmd_wdata, seeds_lit[pass_no]);
            if (widx == 0 && pass_no == 0)
              check(cmd_addr == 0 && cmd_wdata == 16'h01FE, "R1 first write after reset",
                    cmd_wdata, 16'h01FE);
            widx++;
          end else begin
            check(1'b0, "R4 write during read phase", ridx, NW);
          end
        end else begin
          check(widx == NW, "R4 read before write phase complete", widx, NW);
          check(ridx < NW && cmd_addr == AW'(ridx * 4), "R4 read address",
                cmd_addr, ridx * 4);
          ridx++;
        end
      end
      hold_p = cmd_valid && !cmd_ack;
      h_addr = cmd_addr; h_data = cmd_wdata; h_wr = cmd_write;
      pc_p = pass_count; fc_p = fail_count;
    end
  end

  initial begin
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(pass_count == 0, "R1 pass count at reset", pass_count, 0);
    check(fail_count == 0, "R1 fail count at reset", fail_count, 0);
    check(cmd_valid == 0, "R1 no request at reset", cmd_valid, 0);

    // Reset in the middle of the write phase of the fourth pass.
    while (!((pass_no == 3 && widx >= 5) || timed_out)) @(negedge clk);
    check(pass_count == 2 && fail_count == 1, "R7 R8 counts before mid-pass reset",
          {pass_count, fail_count}, 8'h21);
    @(posedge clk);
    #1 rst = 1'b1;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(pass_count == 0 && fail_count == 0, "R1 counters cleared by reset",
          {pass_count, fail_count}, 0);
    check(cmd_valid == 0, "R1 request dropped by reset", cmd_valid, 0);

    while (!(pass_no == NPASS || timed_out)) @(negedge clk);
    @(negedge clk);
    check(pass_count == 4'(NPASS / 2), "R9 pass count wrapped", pass_count, NPASS / 2 % 16);
    check(fail_count == 4'(NPASS / 2), "R9 fail count wrapped", fail_count, NPASS / 2 % 16);

    if (timed_out) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    end
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule